// File: doc/BRIEF.md
# One-Time-Programmable Array Security Lock

The block sits behind a programming front end and owns two small one-time-programmable stores. One is a code array of `CODE_DEPTH` bytes. The other is a 32-byte key array. The front end presents one command at a time: a strobe, a program/verify flag, an array select, an address and a data byte. The block decides whether the command is allowed. It updates the storage or returns read data, and pulses either a done or an error flag on the next clock.

Two sticky lock bits protect the contents:

- The program lock stops any further writes to both arrays. It also hides the key array.
- The verify lock hides both arrays.

Neither lock affects the reporting of the lock bits themselves. Data read back from the code array is always combined with a key byte by XNOR. An erased key therefore returns the stored byte unchanged. A key programmed to zeros returns the complement of the stored byte.

All cells follow one-time-programmable rules and can only move from their erased level to their programmed level. The only way back is the model-wide reset.

Top module: `otp_lock_ctrl`

## Requirements
- R1: After reset every code and key cell reads as 8'hFF, both lock bits are clear, `done` and `err` are low, `rdata` is 8'hFF and `sec_stat` is 2'b00.
- R2: A command strobed in one cycle produces, in the next cycle, exactly one of a one-cycle `done` pulse (accepted) or a one-cycle `err` pulse (rejected); a cycle without a strobe produces neither.
- R3: An accepted code program (`cmd_wr`=1, `cmd_sel`=0) stores the old byte AND `cmd_wdata`, so a cell bit can only go from 1 to 0.
- R4: An accepted code verify (`cmd_wr`=0, `cmd_sel`=0) returns on `rdata` the code byte XNOR the key byte selected by `cmd_addr[4:0]`.
- R5: Key commands use `cmd_sel`=1 and address the key byte with `cmd_addr[4:0]`. A key program ANDs the data into that byte. An accepted key verify returns the byte unchanged.
- R6: Programming `cmd_sel`=2 sets the program lock and `cmd_sel`=3 sets the verify lock, whatever `cmd_addr` and `cmd_wdata` hold. Both are accepted under any lock state, and a set lock never clears before reset.
- R7: A verify with `cmd_sel`=2 or 3 is always accepted and loads `sec_stat`, with bit 1 the program lock and bit 0 the verify lock, each 1 when set.
- R8: With the program lock set, any program of the code or key array is rejected and leaves the storage unchanged.
- R9: With the program lock set, a key verify is rejected while a code verify is still accepted.
- R10: With the verify lock set, code and key verifies are both rejected. Programming stays governed only by the program lock.
- R11: A rejected verify drives `rdata` to 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores the erased model |
| cmd_stb | input | 1 | Command strobe, one cycle per command |
| cmd_wr | input | 1 | 1 = program, 0 = verify |
| cmd_sel | input | 2 | 0 code, 1 key, 2 program lock, 3 verify lock |
| cmd_addr | input | AW | Code address; low 5 bits pick the key byte |
| cmd_wdata | input | 8 | Program data |
| done | output | 1 | One-cycle accepted pulse |
| err | output | 1 | One-cycle rejected pulse |
| rdata | output | 8 | Verify result |
| sec_stat | output | 2 | Lock levels from the last lock-bit verify |

## Verification
On every cycle, the assertions check four things:

- Each strobe yields exactly one of done or error, and idle cycles yield neither.
- Each lock stays set once set.
- Every command that a lock forbids comes back as an error, with all-ones data for a forbidden verify.
- A lock-bit verify reports the lock levels in their correct positions.

Only the bench scenarios can show the actual array contents. That covers AND-only programming, XNOR scrambling by the addressed key byte, and storage left intact after rejected writes, all seen through later verifies. The same holds for the return to the erased state after a second reset.

// File: rtl/otp_lock_ctrl.sv
module otp_lock_ctrl #(
  parameter int CODE_DEPTH = 512,
  parameter int KEY_DEPTH  = 32,
  parameter int DW         = 8,
  localparam int AW = $clog2(CODE_DEPTH),
  localparam int KW = $clog2(KEY_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_stb,
  input  logic          cmd_wr,
  input  logic [1:0]    cmd_sel,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic [1:0]    sec_stat
);

  localparam logic [1:0] SEL_CODE = 2'd0;
  localparam logic [1:0] SEL_KEY  = 2'd1;
  localparam logic [1:0] SEL_LKP  = 2'd2;
  localparam logic [1:0] SEL_LKV  = 2'd3;

  logic [DW-1:0] code_mem [CODE_DEPTH];
  logic [DW-1:0] key_mem  [KEY_DEPTH];
  logic          lock_pgm, lock_ver;

  logic [KW-1:0] key_idx;
  logic [DW-1:0] code_rd, key_rd;
  logic          deny_pgm, deny_ver, reject, is_arr;

  assign key_idx  = cmd_addr[KW-1:0];
  assign code_rd  = code_mem[cmd_addr];
  assign key_rd   = key_mem[key_idx];
  assign is_arr   = ~cmd_sel[1];
  assign deny_pgm = is_arr & lock_pgm;
  assign deny_ver = (cmd_sel == SEL_KEY)  ? (lock_pgm | lock_ver) :
                    (cmd_sel == SEL_CODE) ? lock_ver : 1'b0;
  assign reject   = cmd_wr ? deny_pgm : deny_ver;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CODE_DEPTH; i++) code_mem[i] <= '1;
      for (int i = 0; i < KEY_DEPTH; i++)  key_mem[i]  <= '1;
    end else if (cmd_stb && cmd_wr && !reject) begin
      if (cmd_sel == SEL_CODE) code_mem[cmd_addr] <= code_rd & cmd_wdata;
      if (cmd_sel == SEL_KEY)  key_mem[key_idx]   <= key_rd & cmd_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_pgm <= 1'b0;
      lock_ver <= 1'b0;
    end else if (cmd_stb && cmd_wr) begin
      if (cmd_sel == SEL_LKP) lock_pgm <= 1'b1;
      if (cmd_sel == SEL_LKV) lock_ver <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      err      <= 1'b0;
      rdata    <= '1;
      sec_stat <= 2'b00;
    end else begin
      done <= cmd_stb & ~reject;
      err  <= cmd_stb & reject;
      if (cmd_stb && !cmd_wr) begin
        if (reject)                 rdata    <= '1;
        else if (cmd_sel == SEL_CODE) rdata  <= code_rd ~^ key_rd;
        else if (cmd_sel == SEL_KEY)  rdata  <= key_rd;
        else                          sec_stat <= {lock_pgm, lock_ver};
      end
    end
  end

endmodule

module otp_lock_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_stb,
  input logic          cmd_wr,
  input logic [1:0]    cmd_sel,
  input logic          done,
  input logic          err,
  input logic [DW-1:0] rdata,
  input logic [1:0]    sec_stat,
  input logic          lock_pgm,
  input logic          lock_ver
);

  assert_stb_one_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> (done ^ err));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_stb |=> (!done && !err));

  assert_lock_pgm_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pgm |=> lock_pgm);

  assert_lock_ver_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_ver |=> lock_ver);

  assert_sec_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !cmd_wr && cmd_sel[1]) |=> (done && sec_stat == {lock_pgm, lock_ver}));

  assert_pgm_denied_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_wr && !cmd_sel[1] && lock_pgm) |=> err);

  assert_key_ver_denied_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !cmd_wr && cmd_sel == 2'd1 && lock_pgm) |=> (err && rdata == '1));

  assert_code_ver_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !cmd_wr && cmd_sel == 2'd0 && lock_pgm && !lock_ver) |=> done);

  assert_ver_denied_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !cmd_wr && !cmd_sel[1] && lock_ver) |=> (err && rdata == '1));

  assert_err_ff_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !cmd_wr) ##1 err |-> rdata == '1);

endmodule

bind otp_lock_ctrl otp_lock_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel),
  .done(done), .err(err), .rdata(rdata), .sec_stat(sec_stat),
  .lock_pgm(lock_pgm), .lock_ver(lock_ver)
);

// File: tb/tb_otp_lock_ctrl.sv
module tb_otp_lock_ctrl;
  localparam int AW = 9;
  localparam int N  = 18;

  logic clk = 0, rst_n = 0;
  logic cmd_stb = 0, cmd_wr = 0;
  logic [1:0] cmd_sel = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [7:0] cmd_wdata = 0;
  logic done, err;
  logic [7:0] rdata;
  logic [1:0] sec_stat;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  otp_lock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .done(done), .err(err),
    .rdata(rdata), .sec_stat(sec_stat)
  );

  // {wr, sel, addr, wdata, exp_err, exp_rdata}
  localparam logic [28:0] VEC [N] = '{
    {1'b0, 2'd0, 9'd5,   8'h00, 1'b0, 8'hFF},
    {1'b1, 2'd0, 9'd5,   8'h3C, 1'b0, 8'h00},
    {1'b0, 2'd0, 9'd5,   8'h00, 1'b0, 8'h3C},
    {1'b1, 2'd0, 9'd5,   8'hF0, 1'b0, 8'h00},
    {1'b0, 2'd0, 9'd5,   8'h00, 1'b0, 8'h30},
    {1'b1, 2'd1, 9'd5,   8'h0F, 1'b0, 8'h00},
    {1'b0, 2'd0, 9'd5,   8'h00, 1'b0, 8'hC0},
    {1'b0, 2'd1, 9'd5,   8'h00, 1'b0, 8'h0F},
    {1'b1, 2'd0, 9'd37,  8'hAA, 1'b0, 8'h00},
    {1'b0, 2'd0, 9'd37,  8'h00, 1'b0, 8'h5A},
    {1'b0, 2'd0, 9'd6,   8'h00, 1'b0, 8'hFF},
    {1'b1, 2'd2, 9'd123, 8'h55, 1'b0, 8'h00},
    {1'b1, 2'd0, 9'd5,   8'h00, 1'b1, 8'h00},
    {1'b0, 2'd0, 9'd5,   8'h00, 1'b0, 8'hC0},
    {1'b1, 2'd1, 9'd5,   8'h00, 1'b1, 8'h00},
    {1'b0, 2'd1, 9'd5,   8'h00, 1'b1, 8'hFF},
    {1'b1, 2'd3, 9'd0,   8'h00, 1'b0, 8'h00},
    {1'b0, 2'd0, 9'd5,   8'h00, 1'b1, 8'hFF}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic wr, input logic [1:0] sel, input logic [AW-1:0] a,
                     input logic [7:0] d);
    @(negedge clk);
    cmd_stb = 1; cmd_wr = wr; cmd_sel = sel; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_stb = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  function automatic string tag(input logic wr, input logic [1:0] sel, input logic e);
    if (wr && sel[1]) return "R6";
    if (wr && e)      return "R8";
    if (wr)           return "R3 R5";
    if (e)            return "R9 R10 R11";
    if (sel == 2'd1)  return "R5";
    return "R3 R4";
  endfunction

  initial begin
    do_reset();
    check("R1", {done, err, rdata, 4'b0, sec_stat}, {1'b0, 1'b0, 8'hFF, 6'b0});

    for (int i = 0; i < N; i++) begin
      logic [28:0] v;
      v = VEC[i];
      cmd(v[28], v[27:26], v[25:17], v[16:9]);
      check(tag(v[28], v[27:26], v[8]), {14'b0, done, err}, {14'b0, !v[8], v[8]});
      if (!v[28]) check(tag(v[28], v[27:26], v[8]), {8'b0, rdata}, {8'b0, v[7:0]});
    end

    @(negedge clk);
    check("R2", {14'b0, done, err}, 16'd0);

    cmd(1'b0, 2'd2, 9'd0, 8'h00);
    check("R7", {13'b0, done, sec_stat}, {13'b0, 1'b1, 2'b11});

    do_reset();
    cmd(1'b0, 2'd0, 9'd5, 8'h00);
    check("R1", {8'b0, rdata}, 16'h00FF);
    cmd(1'b0, 2'd3, 9'd0, 8'h00);
    check("R7", {14'b0, sec_stat}, 16'd0);

    cmd(1'b1, 2'd0, 9'd1, 8'h12);
    cmd(1'b1, 2'd3, 9'd77, 8'hFF);
    check("R6", {14'b0, done, err}, 16'b10);
    cmd(1'b0, 2'd0, 9'd1, 8'h00);
    check("R10", {7'b0, err, rdata}, {7'b0, 1'b1, 8'hFF});
    cmd(1'b0, 2'd1, 9'd1, 8'h00);
    check("R10", {7'b0, err, rdata}, {7'b0, 1'b1, 8'hFF});
    cmd(1'b1, 2'd0, 9'd1, 8'h02);
    check("R10", {14'b0, done, err}, 16'b10);
    cmd(1'b0, 2'd2, 9'd0, 8'h00);
    check("R7", {14'b0, sec_stat}, 16'b01);

    do_reset();
    cmd(1'b1, 2'd1, 9'd3, 8'h00);
    cmd(1'b1, 2'd0, 9'd35, 8'hF0);
    cmd(1'b0, 2'd0, 9'd35, 8'h00);
    check("R4", {8'b0, rdata}, 16'h000F);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule